// File: doc/BRIEF.md
# NAND Flash Host Sequencer

This block sits between a local request port and an asynchronous NAND flash device. Command, address and data bytes share one 8-bit bus, and two latch strobes tell them apart. A request names one of five operations: device reset, status read, page read, page program or block erase. The sequencer turns it into the right run of command, address and data strobe cycles. It waits out the device's busy period on the active-low ready/busy line. It then reports a one-cycle done pulse with an error flag and the most recent status byte. Page data goes out and comes back as a byte stream. The outgoing stream uses a valid/ready pair. Incoming bytes arrive as valid pulses.

Operations are encoded on `req_op` as 0 = reset, 1 = status, 2 = page read, 3 = page program, 4 = block erase. The codes 5 to 7 are invalid. A page is 4352 bytes long and a block is 64 pages. Addresses go out as column low, column high, then row low, middle and high. The device opcodes are 0xFF for reset, 0x70 for status, 0x00/0x30 for read, 0x80/0x10 for program and 0x60/0xD0 for erase. In the status byte, bit 0 set means the operation failed, bit 6 set means ready, and bit 7 set means not write-protected.

Top module: `nand_host_ctrl`

## Requirements
- R1: Until a reset request (op 0) has completed without timeout, every other request is rejected. A rejected request gives a done pulse with `err`=1 one clock after acceptance, and no bus cycle is made.
- R2: While `req_ready` is high the pins idle: `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1. CLE and ALE are never high together, and WE# and RE# are never low together.
- R3: Each write or read strobe is low for exactly STROBE_LO clocks. Successive strobe falls are at least STROBE_LO+STROBE_HI clocks apart, which is 32 ns or more with the defaults at 125 MHz.
- R4: The bus sequences are: reset [FF, wait, 70]; status [70]; read [00, col lo, col hi, row lo, row mid, row hi, 30, wait, data]; program [80, five address bytes, data, 10, wait, 70]. The status byte is read after every 70.
- R5: Erase sends [60, row lo, row mid, row hi, D0, wait, 70] and no column bytes. The low log2(PAGES_PER_BLOCK) row bits (6 by default) are sent as zero.
- R6: A program sends exactly `req_len` data bytes. Each byte is taken from `wr_data` in a cycle where `wr_valid` and `wr_ready` are both high, and the bytes go out in order. A length of zero sends no data cycle.
- R7: A page read delivers exactly `req_len` bytes on `rd_data` with `rd_valid` pulses, in device output order.
- R8: After a command that makes the device busy, no new strobe starts until ready/busy is high again. Ready/busy is not sampled until TWB_CLKS clocks have passed.
- R9: If ready/busy stays low longer than `tmo_limit` clocks, the operation ends with done and `err`=1, and no data or status cycle follows.
- R10: `nand_wp_n` is the inverse of `wp_req`. While `wp_req`=1, program and erase requests are rejected as in R1, with no bus cycle.
- R11: After reset, program and erase, `status` holds the byte read after 0x70. For program and erase, `err` equals status bit 0.
- R12: A read or program whose column plus length exceeds PAGE_BYTES is rejected. Op codes 5 to 7 are rejected.
- R13: `done` is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_op | input | 3 | Operation code |
| req_row | input | 24 | Row (block and page) address |
| req_col | input | 16 | Column (byte within page) address |
| req_len | input | 13 | Byte count for read or program |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| tmo_limit | input | 20 | Busy timeout in clocks |
| wp_req | input | 1 | Assert device write protection |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Rejection, timeout or device fail, valid with done |
| status | output | 8 | Last captured device status byte |
| wr_valid | input | 1 | Program data byte available |
| wr_data | input | 8 | Program data byte |
| wr_ready | output | 1 | Program data byte taken this clock |
| rd_valid | output | 1 | Read data byte valid for one clock |
| rd_data | output | 8 | Read data byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable, active high |
| nand_ale | output | 1 | Address latch enable, active high |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_o | output | 8 | Bus value driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus value from the device |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
Several pin-level rules are checked on every clock: idle pin levels, latch-enable and strobe exclusivity, the minimum low width of each write strobe, the ban on strobes while the device is busy, early rejection with write protection or before the first reset, and the single-clock done pulse. Other behaviour depends on device answers and whole operations, so only the bench scenarios show it. This covers the exact byte order of each opcode and address run, erase row masking, the count and order of data bytes, the status-to-error mapping, timeout handling and rejection at the page boundary.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;

  localparam logic [2:0] OP_RESET  = 3'd0;
  localparam logic [2:0] OP_STATUS = 3'd1;
  localparam logic [2:0] OP_READ   = 3'd2;
  localparam logic [2:0] OP_PROG   = 3'd3;
  localparam logic [2:0] OP_ERASE  = 3'd4;

  localparam logic [7:0] OPC_RESET  = 8'hFF;
  localparam logic [7:0] OPC_STATUS = 8'h70;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2,
    S_WAIT, S_RDATA, S_STCMD, S_STRD, S_FIN
  } nfc_state_e;

  function automatic logic [7:0] lead_opcode(input logic [2:0] op);
    case (op)
      OP_READ:  lead_opcode = 8'h00;
      OP_PROG:  lead_opcode = 8'h80;
      OP_ERASE: lead_opcode = 8'h60;
      default:  lead_opcode = OPC_RESET;
    endcase
  endfunction

  function automatic logic [7:0] tail_opcode(input logic [2:0] op);
    case (op)
      OP_READ:  tail_opcode = 8'h30;
      OP_PROG:  tail_opcode = 8'h10;
      default:  tail_opcode = 8'hD0;
    endcase
  endfunction

endpackage

// File: rtl/nfc_cycle_gen.sv
`timescale 1ns/1ps
module nfc_cycle_gen #(
  parameter int unsigned LO = 2,
  parameter int unsigned HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_rd,
  output logic we_n,
  output logic re_n,
  output logic sample,
  output logic last
);
  localparam int unsigned CYC = LO + HI;
  localparam int unsigned CW  = $clog2(CYC + 1);

  logic          act_q, act_d;
  logic          rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          low;

  assign last   = act_q && (cnt_q == CW'(CYC - 1));
  assign low    = act_q && (cnt_q < CW'(LO));
  assign we_n   = !(low && !rd_q);
  assign re_n   = !(low && rd_q);
  assign sample = act_q && rd_q && (cnt_q == CW'(LO - 1));

  always_comb begin
    act_d = act_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        rd_d  = is_rd;
        cnt_d = '0;
      end
    end else if (last) begin
      act_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nfc_busy_wait.sv
`timescale 1ns/1ps
module nfc_busy_wait #(
  parameter int unsigned TWB   = 6,
  parameter int unsigned TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rb_n,
  input  logic [TMO_W-1:0] limit,
  output logic             ready,
  output logic             tmo
);
  typedef enum logic [1:0] {W_IDLE, W_HOLD, W_POLL} wphase_e;

  wphase_e          ph_q, ph_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    ready = 1'b0;
    tmo   = 1'b0;
    case (ph_q)
      W_IDLE: if (start) begin
        ph_d  = W_HOLD;
        cnt_d = '0;
      end
      W_HOLD: if (cnt_q == TMO_W'(TWB - 1)) begin
        ph_d  = W_POLL;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      W_POLL: if (rb_n) begin
        ready = 1'b1;
        ph_d  = W_IDLE;
      end else if (cnt_q >= limit) begin
        tmo   = 1'b1;
        ph_d  = W_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: ph_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nand_host_ctrl.sv
`timescale 1ns/1ps
module nand_host_ctrl
  import nfc_pkg::*;
#(
  parameter int unsigned STROBE_LO       = 2,
  parameter int unsigned STROBE_HI       = 2,
  parameter int unsigned TWB_CLKS        = 6,
  parameter int unsigned TMO_W           = 20,
  parameter int unsigned PAGE_BYTES      = 4352,
  parameter int unsigned PAGES_PER_BLOCK = 64,
  localparam int unsigned LEN_W          = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_row,
  input  logic [15:0]      req_col,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             wp_req,
  output logic             done,
  output logic             err,
  output logic [7:0]       status,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic             nand_wp_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_n
);
  localparam int unsigned PG_BITS  = $clog2(PAGES_PER_BLOCK);
  localparam logic [23:0] ROW_MASK = ~24'(PAGES_PER_BLOCK - 1);
  localparam int unsigned END_W    = (LEN_W > 16 ? LEN_W : 16) + 1;

  nfc_state_e       state_q, state_d;
  logic [2:0]       op_q, op_d;
  logic [23:0]      row_q, row_d;
  logic [15:0]      col_q, col_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             infl_q, infl_d;
  logic [7:0]       dq_q, dq_d;
  logic             err_q, err_d;
  logic [7:0]       stat_q, stat_d;
  logic             init_q, init_d;
  logic             rdv_q, rdv_d;
  logic [7:0]       rdd_q, rdd_d;
  logic [1:0]       rb_sync_q;

  logic cg_start, cg_rd, cg_sample, cg_last;
  logic bw_start, bw_ready, bw_tmo;
  logic reject, is_wr_state;
  logic [7:0] addr_byte;

  nfc_cycle_gen #(.LO(STROBE_LO), .HI(STROBE_HI)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(cg_start), .is_rd(cg_rd),
    .we_n(nand_we_n), .re_n(nand_re_n), .sample(cg_sample), .last(cg_last)
  );

  nfc_busy_wait #(.TWB(TWB_CLKS), .TMO_W(TMO_W)) u_bw (
    .clk(clk), .rst_n(rst_n), .start(bw_start), .rb_n(rb_sync_q[1]),
    .limit(tmo_limit), .ready(bw_ready), .tmo(bw_tmo)
  );

  always_comb begin
    case (cnt_q[2:0])
      3'd0:    addr_byte = col_q[7:0];
      3'd1:    addr_byte = col_q[15:8];
      3'd2:    addr_byte = row_q[7:0];
      3'd3:    addr_byte = row_q[15:8];
      default: addr_byte = row_q[23:16];
    endcase
  end

  always_comb begin
    reject = 1'b0;
    if (req_op > OP_ERASE) reject = 1'b1;
    if (req_op != OP_RESET && !init_q) reject = 1'b1;
    if (wp_req && (req_op == OP_PROG || req_op == OP_ERASE)) reject = 1'b1;
    if ((req_op == OP_READ || req_op == OP_PROG) &&
        (END_W'(req_col) + END_W'(req_len) > END_W'(PAGE_BYTES))) reject = 1'b1;
  end

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    row_d    = row_q;
    col_d    = col_q;
    len_d    = len_q;
    cnt_d    = cnt_q;
    infl_d   = infl_q;
    dq_d     = dq_q;
    err_d    = err_q;
    stat_d   = stat_q;
    init_d   = init_q;
    rdv_d    = 1'b0;
    rdd_d    = rdd_q;
    cg_start = 1'b0;
    cg_rd    = 1'b0;
    bw_start = 1'b0;
    wr_ready = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        op_d    = req_op;
        row_d   = (req_op == OP_ERASE) ? (req_row & ROW_MASK) : req_row;
        col_d   = req_col;
        len_d   = req_len;
        cnt_d   = '0;
        err_d   = reject;
        if (reject)                 state_d = S_FIN;
        else if (req_op == OP_STATUS) state_d = S_STCMD;
        else                        state_d = S_CMD1;
      end
      S_CMD1: begin
        if (!infl_q) begin
          cg_start = 1'b1; infl_d = 1'b1; dq_d = lead_opcode(op_q);
        end
        if (cg_last) begin
          infl_d = 1'b0;
          if (op_q == OP_RESET) state_d = S_WAIT;
          else begin
            state_d = S_ADDR;
            cnt_d   = (op_q == OP_ERASE) ? LEN_W'(2) : '0;
          end
        end
      end
      S_ADDR: begin
        if (!infl_q) begin
          cg_start = 1'b1; infl_d = 1'b1; dq_d = addr_byte;
        end
        if (cg_last) begin
          infl_d = 1'b0;
          if (cnt_q == LEN_W'(4)) begin
            cnt_d   = '0;
            state_d = (op_q == OP_PROG) ? S_WDATA : S_CMD2;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_WDATA: begin
        if (!infl_q) begin
          if (cnt_q == len_q) begin
            cnt_d = '0; state_d = S_CMD2;
          end else if (wr_valid) begin
            wr_ready = 1'b1; cg_start = 1'b1; infl_d = 1'b1; dq_d = wr_data;
          end
        end
        if (cg_last) begin
          infl_d = 1'b0; cnt_d = cnt_q + 1'b1;
        end
      end
      S_CMD2: begin
        if (!infl_q) begin
          cg_start = 1'b1; infl_d = 1'b1; dq_d = tail_opcode(op_q);
        end
        if (cg_last) begin
          infl_d = 1'b0; state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        if (!infl_q) begin
          bw_start = 1'b1; infl_d = 1'b1;
        end
        if (bw_ready) begin
          infl_d  = 1'b0;
          cnt_d   = '0;
          state_d = (op_q == OP_READ) ? S_RDATA : S_STCMD;
        end else if (bw_tmo) begin
          infl_d  = 1'b0;
          err_d   = 1'b1;
          state_d = S_FIN;
        end
      end
      S_RDATA: begin
        if (!infl_q) begin
          if (cnt_q == len_q) state_d = S_FIN;
          else begin
            cg_start = 1'b1; cg_rd = 1'b1; infl_d = 1'b1;
          end
        end
        if (cg_sample) begin
          rdv_d = 1'b1; rdd_d = nand_dq_i;
        end
        if (cg_last) begin
          infl_d = 1'b0; cnt_d = cnt_q + 1'b1;
        end
      end
      S_STCMD: begin
        if (!infl_q) begin
          cg_start = 1'b1; infl_d = 1'b1; dq_d = OPC_STATUS;
        end
        if (cg_last) begin
          infl_d = 1'b0; state_d = S_STRD;
        end
      end
      S_STRD: begin
        if (!infl_q) begin
          cg_start = 1'b1; cg_rd = 1'b1; infl_d = 1'b1;
        end
        if (cg_sample) begin
          stat_d = nand_dq_i;
          err_d  = (op_q == OP_PROG || op_q == OP_ERASE) && nand_dq_i[0];
        end
        if (cg_last) begin
          infl_d = 1'b0; state_d = S_FIN;
        end
      end
      S_FIN: begin
        state_d = S_IDLE;
        if (op_q == OP_RESET && !err_q) init_d = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      op_q      <= OP_RESET;
      row_q     <= '0;
      col_q     <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      infl_q    <= 1'b0;
      dq_q      <= '0;
      err_q     <= 1'b0;
      stat_q    <= '0;
      init_q    <= 1'b0;
      rdv_q     <= 1'b0;
      rdd_q     <= '0;
      rb_sync_q <= 2'b00;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      row_q     <= row_d;
      col_q     <= col_d;
      len_q     <= len_d;
      cnt_q     <= cnt_d;
      infl_q    <= infl_d;
      dq_q      <= dq_d;
      err_q     <= err_d;
      stat_q    <= stat_d;
      init_q    <= init_d;
      rdv_q     <= rdv_d;
      rdd_q     <= rdd_d;
      rb_sync_q <= {rb_sync_q[0], nand_rb_n};
    end
  end

  assign is_wr_state = (state_q == S_CMD1) || (state_q == S_ADDR) ||
                       (state_q == S_WDATA) || (state_q == S_CMD2) ||
                       (state_q == S_STCMD);
  assign req_ready  = (state_q == S_IDLE);
  assign done       = (state_q == S_FIN);
  assign err        = err_q;
  assign status     = stat_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign nand_ce_n  = (state_q == S_IDLE) || (state_q == S_FIN);
  assign nand_cle   = infl_q && ((state_q == S_CMD1) || (state_q == S_CMD2) ||
                                 (state_q == S_STCMD));
  assign nand_ale   = infl_q && (state_q == S_ADDR);
  assign nand_dq_oe = infl_q && is_wr_state;
  assign nand_dq_o  = dq_q;
  assign nand_wp_n  = !wp_req;
endmodule

// File: rtl/nfc_host_chk.sv
`timescale 1ns/1ps
module nfc_host_chk #(
  parameter int unsigned LO = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       req_ready,
  input logic       wp_req,
  input logic       init_q,
  input logic       done,
  input logic       err,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_rb_n
);
  logic [7:0] we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               we_lo_cnt <= '0;
    else if (nand_we_n)       we_lo_cnt <= '0;
    else if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 1'b1;
  end

  a_r1_reject_uninit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_op != 3'd0 && !init_q) |=> (done && err && nand_ce_n));

  a_r2_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n));

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (we_lo_cnt >= 8'(LO)));

  a_r8_no_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> nand_rb_n);

  a_r10_wp_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && wp_req && (req_op == 3'd3 || req_op == 3'd4))
      |=> (done && err && nand_ce_n));

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind nand_host_ctrl nfc_host_chk #(.LO(STROBE_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_ready(req_ready), .wp_req(wp_req), .init_q(init_q), .done(done),
  .err(err), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n)
);

// File: tb/nand_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_host_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [12:0] req_len = '0;
  logic        req_ready;
  logic [19:0] tmo_limit = 20'd1000;
  logic        wp_req = 1'b0;
  logic        done, err;
  logic [7:0]  status;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data;
  logic        wr_ready;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
  logic [7:0]  nand_dq_o;
  logic        nand_dq_oe;
  logic [7:0]  model_dq = '0;
  logic        nand_rb_n;

  always #4 clk = ~clk;

  nand_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_ready(req_ready),
    .tmo_limit(tmo_limit), .wp_req(wp_req), .done(done), .err(err), .status(status),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(model_dq),
    .nand_rb_n(nand_rb_n)
  );

  int n_chk = 0;
  int n_err = 0;

  // ---- device model ----
  bit   model_en = 0;
  int   blog [0:31];
  int   log_n = 0;
  logic [7:0] wlog [0:63];
  int   wn = 0;
  int   addr_idx = 0;
  int   col_ptr = 0;
  bit   st_mode = 0;
  bit   fail_bit = 0;
  int   busy_len = 30;
  int   kick_seq = 0, kick_seen = 0, busy_cnt = 0;
  int   viol = 0;
  logic [7:0] wbuf [0:63];
  int   wr_idx = 0;
  logic [7:0] rlog [0:63];
  int   rn = 0;
  int   done_cnt = 0;
  longint last_fall = -1, min_per = 1000, min_lo = 1000;
  longint re_fall = -1, min_re_lo = 1000;

  assign nand_rb_n = (busy_cnt == 0);
  assign wr_data   = wbuf[wr_idx[5:0]];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  always @(posedge nand_we_n) if (model_en && !nand_ce_n) begin
    if (nand_cle) begin
      if (log_n < 32) blog[log_n] = 32'h100 | int'(nand_dq_o);
      log_n++;
      addr_idx = 0;
      st_mode = (nand_dq_o == 8'h70);
      if (nand_dq_o == 8'hFF || nand_dq_o == 8'h30 || nand_dq_o == 8'h10 ||
          nand_dq_o == 8'hD0) kick_seq++;
    end else if (nand_ale) begin
      if (log_n < 32) blog[log_n] = 32'h200 | int'(nand_dq_o);
      log_n++;
      if (addr_idx == 0) col_ptr = int'(nand_dq_o);
      if (addr_idx == 1) col_ptr = col_ptr | (int'(nand_dq_o) << 8);
      addr_idx++;
    end else begin
      if (wn < 64) wlog[wn] = nand_dq_o;
      wn++;
    end
    if (last_fall >= 0 && $time - last_fall < min_lo) min_lo = $time - last_fall;
  end

  always @(negedge nand_we_n) if (model_en) begin
    if (!nand_rb_n) viol++;
    if (last_fall >= 0 && $time - last_fall < min_per) min_per = $time - last_fall;
    last_fall = $time;
  end

  always @(negedge nand_re_n) if (model_en) begin
    model_dq = st_mode ? {nand_wp_n, 1'b1, 5'b0, fail_bit} : pat(col_ptr);
    re_fall = $time;
  end

  always @(posedge nand_re_n) if (model_en) begin
    if (!st_mode) col_ptr++;
    if (re_fall >= 0 && $time - re_fall < min_re_lo) min_re_lo = $time - re_fall;
  end

  always @(posedge clk) begin
    if (kick_seq != kick_seen) begin
      kick_seen <= kick_seq;
      busy_cnt  <= busy_len;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
  end

  always @(negedge clk) begin
    if (rd_valid) begin
      if (rn < 64) rlog[rn] = rd_data;
      rn++;
    end
    if (done) done_cnt++;
  end

  // ---- checking helpers ----
  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int   exp_log [0:31];
  int   exp_n;
  bit   got_err;
  logic [7:0] got_stat;

  function automatic void add_exp(input int v);
    exp_log[exp_n] = v;
    exp_n++;
  endfunction

  function automatic void build_exp(input int op, input int row, input int col, input int len);
    int r;
    exp_n = 0;
    r = (op == 4) ? (row & ~63) : row;
    case (op)
      0: begin add_exp('h1FF); add_exp('h170); end
      1: add_exp('h170);
      2, 3: begin
        add_exp(op == 2 ? 'h100 : 'h180);
        add_exp('h200 | (col & 255)); add_exp('h200 | ((col >> 8) & 255));
        add_exp('h200 | (r & 255)); add_exp('h200 | ((r >> 8) & 255));
        add_exp('h200 | ((r >> 16) & 255));
        add_exp(op == 2 ? 'h130 : 'h110);
        if (op == 3) add_exp('h170);
      end
      4: begin
        add_exp('h160);
        add_exp('h200 | (r & 255)); add_exp('h200 | ((r >> 8) & 255));
        add_exp('h200 | ((r >> 16) & 255));
        add_exp('h1D0); add_exp('h170);
      end
      default: exp_n = 0;
    endcase
  endfunction

  task automatic run_op(input int op, input int row, input int col, input int len);
    int d0;
    bit seen;
    while (!req_ready) @(negedge clk);
    log_n = 0; wn = 0; rn = 0;
    wr_idx = 0;
    d0 = done_cnt;
    req_op = 3'(op); req_row = 24'(row); req_col = 16'(col); req_len = 13'(len);
    wr_valid = (op == 3);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin
        seen = 1; got_err = err; got_stat = status;
        break;
      end
      @(negedge clk);
    end
    if (!seen) chk("R13 watchdog on done", 0, 1);
    wr_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R13 one done per request", done_cnt - d0, 1);
  endtask

  task automatic chk_log(input string req);
    chk(req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) chk(req, blog[i], exp_log[i]);
  endtask

  initial begin : wdog
    #(8 * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int row, col, len, sd;
    sd = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_en = 1;

    // R2 reset state
    chk("R2 req_ready idle", req_ready, 1);
    chk("R2 ce_n idle", nand_ce_n, 1);
    chk("R2 cle/ale idle", {nand_cle, nand_ale}, 0);
    chk("R2 we_n/re_n idle", {nand_we_n, nand_re_n}, 2'b11);
    chk("R13 done idle", done, 0);

    // R1 reject before first reset
    run_op(1, 0, 0, 0);
    chk("R1 status before reset err", got_err, 1);
    chk("R1 no bus cycle", log_n, 0);
    run_op(2, 5, 0, 4);
    chk("R1 read before reset err", got_err, 1);
    chk("R1 no bus cycle", log_n, 0);

    // R4 reset, R11 status
    run_op(0, 0, 0, 0);
    build_exp(0, 0, 0, 0);
    chk_log("R4 reset sequence");
    chk("R11 reset err", got_err, 0);
    chk("R11 reset status", got_stat, 8'hC0);
    run_op(1, 0, 0, 0);
    build_exp(1, 0, 0, 0);
    chk_log("R4 status sequence");
    chk("R11 status op err", got_err, 0);

    // R10 write protect
    wp_req = 1'b1;
    @(negedge clk);
    chk("R10 wp pin low", nand_wp_n, 0);
    run_op(3, 100, 0, 4);
    chk("R10 program rejected", got_err, 1);
    chk("R10 program no bus", log_n, 0);
    run_op(4, 100, 0, 0);
    chk("R10 erase rejected", got_err, 1);
    chk("R10 erase no bus", log_n, 0);
    wp_req = 1'b0;
    @(negedge clk);
    chk("R10 wp pin high", nand_wp_n, 1);

    // R5 erase with page bits masked
    fail_bit = 0;
    run_op(4, 'h012345, 0, 0);
    build_exp(4, 'h012345, 0, 0);
    chk_log("R5 erase sequence");
    chk("R11 erase pass", got_err, 0);
    fail_bit = 1;
    run_op(4, 'hABCDEF, 0, 0);
    build_exp(4, 'hABCDEF, 0, 0);
    chk_log("R5 erase sequence masked");
    chk("R11 erase fail err", got_err, 1);
    chk("R11 erase fail status", got_stat, 8'hC1);
    fail_bit = 0;

    // random program/read mix
    for (int it = 0; it < 8; it++) begin
      len = 1 + ($urandom % 16);
      col = $urandom % (4352 - len + 1);
      row = $urandom & 'hFFFFFF;
      if (it % 2 == 0) begin
        fail_bit = $urandom % 2;
        for (int k = 0; k < 64; k++) wbuf[k] = 8'($urandom);
        run_op(3, row, col, len);
        build_exp(3, row, col, len);
        chk_log("R4 program sequence");
        chk("R6 data count", wn, len);
        for (int k = 0; k < len; k++) chk("R6 data byte", wlog[k], wbuf[k]);
        chk("R11 program err", got_err, fail_bit);
        chk("R11 program status", got_stat, {1'b1, 1'b1, 5'b0, fail_bit});
      end else begin
        run_op(2, row, col, len);
        build_exp(2, row, col, len);
        chk_log("R4 read sequence");
        chk("R7 read count", rn, len);
        for (int k = 0; k < len; k++) chk("R7 read byte", rlog[k], pat(col + k));
        chk("R7 read err", got_err, 0);
      end
    end
    fail_bit = 0;

    // R6 zero-length program
    run_op(3, 'h000040, 7, 0);
    build_exp(3, 'h000040, 7, 0);
    chk_log("R6 zero length program");
    chk("R6 zero length no data", wn, 0);

    // R12 page boundary
    run_op(2, 1, 4350, 3);
    chk("R12 over page end rejected", got_err, 1);
    chk("R12 no bus", log_n, 0);
    run_op(2, 1, 4350, 2);
    chk("R12 at page end accepted", got_err, 0);
    chk("R12 at page end count", rn, 2);
    chk("R12 at page end byte", rlog[1], pat(4351));
    run_op(6, 0, 0, 0);
    chk("R12 invalid op rejected", got_err, 1);
    chk("R12 invalid op no bus", log_n, 0);

    // R3 strobe timing, R8 no strobe while busy
    chk("R3 we low width ns", min_lo, 16);
    chk("R3 re low width ns", min_re_lo, 16);
    chk("R3 strobe period >= 32ns", (min_per >= 32) ? 1 : 0, 1);
    chk("R8 no strobe while busy", viol, 0);

    // R9 timeout
    tmo_limit = 20'd20;
    busy_len = 300;
    run_op(2, 3, 0, 4);
    chk("R9 timeout err", got_err, 1);
    chk("R9 no data after timeout", rn, 0);
    build_exp(2, 3, 0, 4);
    chk_log("R9 sequence up to busy");
    while (!nand_rb_n) @(negedge clk);
    repeat (4) @(negedge clk);
    tmo_limit = 20'd1000;
    busy_len = 30;
    run_op(1, 0, 0, 0);
    chk("R9 recovers after timeout", got_err, 0);
    chk("R8 no strobe while busy final", viol, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule